// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Slave Interface

This block sits between an 8051-style host bus and the internal storage of a peripheral. The host puts the low address byte and the data byte on one shared set of eight lines. It marks the address phase with an address-latch strobe and drives the upper address byte on dedicated lines. The block brings every bus pin into its own clock domain through a two-stage synchroniser. It delays all pins together so that address, data and strobes stay aligned. It keeps the low address byte in a latch that is open while the latch strobe is high.

A small base register places an 8 KiB window anywhere in the 64 KiB host space. It holds the upper three address bits of that window. Inside the window, a 16-byte register region sits at a fixed offset and every other offset goes to memory. Offset bit 12 picks one of two 4 KiB memory planes. Reads are accepted on either the program-fetch strobe or the data-read strobe, so the window is visible in both host spaces. Writes are committed on the rising edge of the write strobe. The host can move the window by writing the base register, which is the last register of the region.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `ad_oe_o`, `mem_rd_o`, `reg_rd_o`, `mem_wr_o` and `reg_wr_o` are 0, `wr_addr_o` and `wdata_o` are 0, and the window base equals parameter `BASE_RST` (default 1, window 0x2000-0x3FFF).
- R2: While the synchronised latch strobe is high, the low address byte follows `ad_i`. After the strobe falls, the byte is held, so later traffic on `ad_i` does not change `rd_addr_o`. `rd_addr_o` is the 13-bit offset {upper byte, latched byte}[12:0].
- R3: An access takes effect only if address bits [15:13] equal the base register. Outside the window there is no read enable, no drive of `ad_o` and no write pulse.
- R4: With `ce_ni` high, reads neither drive nor enable, and writes produce no pulse.
- R5: A read is active while `psen_ni` or `rd_ni` is low, the chip is selected and the address hits. Only then is `ad_oe_o` 1, and `ad_o` carries the read data; otherwise `ad_o` is 0.
- R6: Offsets 0x1FF0-0x1FFF select the register region (`reg_rd_o`/`reg_wr_o`, index in offset bits [3:0]). All other offsets select memory (`mem_rd_o`/`mem_wr_o`), with offset bit 12 choosing the plane.
- R7: A rising edge on `wr_ni` produces a one-cycle `mem_wr_o` or `reg_wr_o`. At that pulse, `wr_addr_o` shows the offset and `wdata_o` shows the data present on `ad_i` while `wr_ni` was still low. Both hold until the next pulse.
- R8: Register index 15 is the base register. A write loads `ad_i[2:0]` into the base with no `reg_wr_o` pulse and no update of `wr_addr_o`/`wdata_o`. A read returns the base zero-extended, with no `reg_rd_o`.
- R9: Read enables and `ad_oe_o` respond two clock edges after a strobe pin falls. The write pulse appears on the third clock edge after `wr_ni` rises.
- R10: At most one of `mem_wr_o`/`reg_wr_o`, and at most one of `mem_rd_o`/`reg_rd_o`, is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address-latch strobe |
| psen_ni | input | 1 | Program-fetch read strobe, active low |
| rd_ni | input | 1 | Data read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ce_ni | input | 1 | Chip enable, active low |
| addr_hi_i | input | 8 | Upper address byte |
| ad_i | input | 8 | Shared address/data lines, input side |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| rd_addr_o | output | 13 | Window offset of the current access |
| mem_rd_o | output | 1 | Memory read enable |
| reg_rd_o | output | 1 | Register read enable |
| rdata_i | input | 8 | Read data for the offset on `rd_addr_o` |
| wr_addr_o | output | 13 | Window offset of the last write |
| wdata_o | output | 8 | Data of the last write |
| mem_wr_o | output | 1 | Memory write pulse |
| reg_wr_o | output | 1 | Register write pulse |

## Verification
The assertions assume that the host follows the bus protocol. Strobe edges are separated by several internal clocks. Chip enable does not change while a write strobe is low. Data on the shared lines stays stable around the write-strobe edge. The bench drives each phase (address, latch close, strobe low, strobe high) for at least two clock cycles, all from the falling clock edge. It keeps chip enable steady across each whole access. It also places junk on the shared lines after the latch closes, to probe the hold behaviour.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int HI_W      = ADDR_W - DATA_W;
  localparam int OFS_W     = 13;
  localparam int BASE_W    = ADDR_W - OFS_W;
  localparam int REG_IDX_W = 4;
  localparam int N_DEC     = 2;  // 0: read path, 1: write path

  typedef struct packed {
    logic              ale;
    logic              psen_n;
    logic              rd_n;
    logic              wr_n;
    logic              ce_n;
    logic [HI_W-1:0]   hi;
    logic [DATA_W-1:0] ad;
  } bus_t;

  localparam bus_t BUS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                ce_n: 1'b1, hi: '0, ad: '0};
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int           W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      q_o  <= RST;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter logic [OFS_W-1:0] REG_OFS = 13'h1FF0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic              is_reg_o,
  output logic              is_base_o,
  output logic [OFS_W-1:0]  ofs_o
);
  assign ofs_o     = addr_i[OFS_W-1:0];
  assign hit_o     = (addr_i[ADDR_W-1:OFS_W] == base_i);
  assign is_reg_o  = (ofs_o[OFS_W-1:REG_IDX_W] == REG_OFS[OFS_W-1:REG_IDX_W]);
  // last register slot holds the window base
  assign is_base_o = is_reg_o & (&ofs_o[REG_IDX_W-1:0]);
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbus_pkg::*;
#(
  parameter logic [BASE_W-1:0] BASE_RST = 3'd1,
  parameter logic [OFS_W-1:0]  REG_OFS  = 13'h1FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              psen_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              ce_ni,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [OFS_W-1:0]  rd_addr_o,
  output logic              mem_rd_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [OFS_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mem_wr_o,
  output logic              reg_wr_o
);
  bus_t bus_in, bus_s2;

  assign bus_in = '{ale: ale_i, psen_n: psen_ni, rd_n: rd_ni, wr_n: wr_ni,
                    ce_n: ce_ni, hi: addr_hi_i, ad: ad_i};

  mbus_sync #(
    .W  ($bits(bus_t)),
    .RST(BUS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_in),
    .q_o   (bus_s2)
  );

  // one extra stage for edge detection and pre-edge data
  logic              q_wr_n, q_ce_n;
  logic [HI_W-1:0]   q_hi;
  logic [DATA_W-1:0] q_ad;
  logic [DATA_W-1:0] lat_lo;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_wr_n <= 1'b1;
      q_ce_n <= 1'b1;
      q_hi   <= '0;
      q_ad   <= '0;
      lat_lo <= '0;
    end else begin
      q_wr_n <= bus_s2.wr_n;
      q_ce_n <= bus_s2.ce_n;
      q_hi   <= bus_s2.hi;
      q_ad   <= bus_s2.ad;
      if (bus_s2.ale) lat_lo <= bus_s2.ad;
    end
  end

  logic [N_DEC-1:0][ADDR_W-1:0] dec_addr;
  logic [N_DEC-1:0]             dec_hit, dec_reg, dec_base;
  logic [N_DEC-1:0][OFS_W-1:0]  dec_ofs;

  assign dec_addr[0] = {bus_s2.hi, lat_lo};
  assign dec_addr[1] = {q_hi, lat_lo};

  for (genvar p = 0; p < N_DEC; p++) begin : g_dec
    mbus_decode #(.REG_OFS(REG_OFS)) u_dec (
      .addr_i   (dec_addr[p]),
      .base_i   (base_q),
      .hit_o    (dec_hit[p]),
      .is_reg_o (dec_reg[p]),
      .is_base_o(dec_base[p]),
      .ofs_o    (dec_ofs[p])
    );
  end

  // write path
  logic wr_rise, wr_fire, base_we;
  assign wr_rise = bus_s2.wr_n & ~q_wr_n;
  assign wr_fire = wr_rise & ~q_ce_n & dec_hit[1];
  assign base_we = wr_fire & dec_base[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wr_o  <= 1'b0;
      reg_wr_o  <= 1'b0;
      wr_addr_o <= '0;
      wdata_o   <= '0;
      base_q    <= BASE_RST;
    end else begin
      mem_wr_o <= wr_fire & ~dec_reg[1];
      reg_wr_o <= wr_fire & dec_reg[1] & ~dec_base[1];
      if (wr_fire && !dec_base[1]) begin
        wr_addr_o <= dec_ofs[1];
        wdata_o   <= q_ad;
      end
      if (base_we) base_q <= q_ad[BASE_W-1:0];
    end
  end

  // read path
  logic rd_act;
  assign rd_act    = (~bus_s2.psen_n | ~bus_s2.rd_n) & ~bus_s2.ce_n & dec_hit[0];
  assign rd_addr_o = dec_ofs[0];
  assign mem_rd_o  = rd_act & ~dec_reg[0];
  assign reg_rd_o  = rd_act & dec_reg[0] & ~dec_base[0];
  assign ad_oe_o   = rd_act;

  always_comb begin
    ad_o = '0;
    if (rd_act) begin
      if (dec_base[0]) ad_o = {{(DATA_W-BASE_W){1'b0}}, base_q};
      else             ad_o = rdata_i;
    end
  end
endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk
  import mbus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_wr_o,
  input logic              reg_wr_o,
  input logic              mem_rd_o,
  input logic              reg_rd_o,
  input logic              ad_oe_o,
  input logic              s2_ce_n,
  input logic              q_ce_n,
  input logic [BASE_W-1:0] base_q,
  input logic              base_we
);
  // R10
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_wr_o, reg_wr_o}));

  // R10
  rd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && reg_rd_o));

  // R7
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || reg_wr_o) |=> !(mem_wr_o || reg_wr_o));

  // R4
  ce_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_ce_n |-> !ad_oe_o);

  // R4
  ce_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || reg_wr_o) |-> $past(!q_ce_n));

  // R5
  rd_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || reg_rd_o) |-> ad_oe_o);

  // R8
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_q) |-> $past(base_we));
endmodule

bind mux_bus_slave mux_bus_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mem_wr_o(mem_wr_o),
  .reg_wr_o(reg_wr_o),
  .mem_rd_o(mem_rd_o),
  .reg_rd_o(reg_rd_o),
  .ad_oe_o (ad_oe_o),
  .s2_ce_n (bus_s2.ce_n),
  .q_ce_n  (q_ce_n),
  .base_q  (base_q),
  .base_we (base_we)
);

// File: tb/tb_mux_bus_slave.sv
`timescale 1ns/1ps
module tb_mux_bus_slave;
  import mbus_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ale = 0, psen_n = 1, rd_n = 1, wr_n = 1, ce_n = 1;
  logic [7:0]  hi = 0, ad = 0;
  logic [7:0]  ad_o, rdata, wdata;
  logic        ad_oe, mem_rd, reg_rd, mem_wr, reg_wr;
  logic [12:0] rd_addr, wr_addr;

  function automatic logic [7:0] mem_val(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]};
  endfunction
  assign rdata = mem_val(rd_addr);

  mux_bus_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .psen_ni(psen_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .ce_ni(ce_n), .addr_hi_i(hi), .ad_i(ad), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .rd_addr_o(rd_addr), .mem_rd_o(mem_rd), .reg_rd_o(reg_rd),
    .rdata_i(rdata), .wr_addr_o(wr_addr), .wdata_o(wdata), .mem_wr_o(mem_wr),
    .reg_wr_o(reg_wr)
  );

  int total = 0, fails = 0;
  int n_mw = 0, n_rw = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: input history, latched byte, base, write outputs
  bus_t h[4];
  logic [7:0]  m_lat;
  logic [2:0]  m_base;
  logic [12:0] m_wa;
  logic [7:0]  m_wd;
  logic        m_mw, m_rw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = BUS_IDLE;
      m_lat = 0; m_base = 3'd1; m_wa = 0; m_wd = 0; m_mw = 0; m_rw = 0;
    end else begin
      logic [15:0] full;
      logic fire, isreg, isbase;
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0];
      h[0] = '{ale: ale, psen_n: psen_n, rd_n: rd_n, wr_n: wr_n, ce_n: ce_n, hi: hi, ad: ad};
      full   = {h[3].hi, m_lat};
      fire   = h[2].wr_n && !h[3].wr_n && !h[3].ce_n && (full[15:13] == m_base);
      isreg  = full[12:0] >= 13'h1FF0;
      isbase = full[12:0] == 13'h1FFF;
      m_mw = fire && !isreg;
      m_rw = fire && isreg && !isbase;
      if (fire && !isbase) begin m_wa = full[12:0]; m_wd = h[3].ad; end
      if (fire && isbase) m_base = h[3].ad[2:0];
      if (h[2].ale) m_lat = h[2].ad;
    end
  end

  // per-cycle comparison, mid high phase
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [15:0] fr;
      logic rd, rg, bs;
      logic [7:0] ed;
      fr = {h[1].hi, m_lat};
      rd = (!h[1].psen_n || !h[1].rd_n) && !h[1].ce_n && (fr[15:13] == m_base);
      rg = fr[12:0] >= 13'h1FF0;
      bs = fr[12:0] == 13'h1FFF;
      ed = !rd ? 8'h00 : (bs ? {5'b0, m_base} : mem_val(fr[12:0]));
      chk("R2 rd_addr", rd_addr, fr[12:0]);
      chk("R5 ad_oe", ad_oe, rd);
      chk("R5 ad_o", ad_o, ed);
      chk("R6 mem_rd", mem_rd, rd && !rg);
      chk("R6 reg_rd", reg_rd, rd && rg && !bs);
      chk("R7 mem_wr", mem_wr, m_mw);
      chk("R7 reg_wr", reg_wr, m_rw);
      chk("R7 wr_addr", wr_addr, m_wa);
      chk("R7 wdata", wdata, m_wd);
      chk("R10 excl", {mem_wr && reg_wr, mem_rd && reg_rd}, 0);
      if (mem_wr) n_mw++;
      if (reg_wr) n_rw++;
    end
  end

  task automatic addr_phase(input logic [15:0] a, input bit ce);
    @(negedge clk); ce_n = !ce; ale = 1; hi = a[15:8]; ad = a[7:0];
    repeat (3) @(negedge clk);
    ale = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit ce,
                           output bit p2, output bit p3);
    addr_phase(a, ce);
    ad = d; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    @(negedge clk); p2 = mem_wr | reg_wr;
    @(negedge clk); p3 = mem_wr | reg_wr;
    ad = 0;
    repeat (2) @(negedge clk);
    ce_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [15:0] a, input bit use_psen, input bit ce,
                          output logic [7:0] d, output bit o1, output bit o2);
    addr_phase(a, ce);
    ad = 8'hFF;
    repeat (2) @(negedge clk);
    if (use_psen) psen_n = 0; else rd_n = 0;
    @(negedge clk); o1 = ad_oe;
    @(negedge clk); o2 = ad_oe; d = ad_o;
    chk("R2 latched low byte held", rd_addr, a[12:0]);
    @(negedge clk);
    psen_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);
    ce_n = 1; ad = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit o1, o2, p2, p3;
    int mw0, rw0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 reg_wr", reg_wr, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 wdata", wdata, 0);

    bus_read(16'h3FFF, 0, 1, d, o1, o2);
    chk("R1 R8 base reads back reset value", d, 8'h01);

    mw0 = n_mw;
    bus_write(16'h2123, 8'hA5, 1, p2, p3);
    chk("R9 no pulse after two edges", p2, 0);
    chk("R9 pulse on third edge", p3, 1);
    chk("R7 mem pulse count", n_mw, mw0 + 1);
    chk("R7 wdata", wdata, 8'hA5);
    chk("R6 wr_addr plane0", wr_addr, 13'h0123);

    bus_write(16'h3456, 8'h3C, 1, p2, p3);
    chk("R6 plane1 offset bit12", wr_addr, 13'h1456);

    rw0 = n_rw; mw0 = n_mw;
    bus_write(16'h3FF3, 8'h77, 1, p2, p3);
    chk("R6 reg write pulse", n_rw, rw0 + 1);
    chk("R6 reg write not memory", n_mw, mw0);
    chk("R6 reg wr_addr", wr_addr, 13'h1FF3);

    mw0 = n_mw; rw0 = n_rw;
    bus_write(16'h4123, 8'h11, 1, p2, p3);
    chk("R3 outside window no pulse", n_mw + n_rw, mw0 + rw0);
    chk("R3 outside window wdata kept", wdata, 8'h77);
    bus_write(16'h2200, 8'h22, 0, p2, p3);
    chk("R4 deselected write ignored", n_mw + n_rw, mw0 + rw0);
    chk("R4 deselected wdata kept", wdata, 8'h77);

    bus_read(16'h2055, 1, 1, d, o1, o2);
    chk("R9 no drive after one edge", o1, 0);
    chk("R5 psen read drives", o2, 1);
    chk("R5 psen read data", d, mem_val(13'h0055));
    bus_read(16'h3002, 0, 1, d, o1, o2);
    chk("R5 rd read drives", o2, 1);
    chk("R5 rd read data", d, mem_val(13'h1002));
    bus_read(16'h3FF5, 0, 1, d, o1, o2);
    chk("R6 register read data", d, mem_val(13'h1FF5));
    bus_read(16'h2055, 0, 0, d, o1, o2);
    chk("R4 deselected read no drive", o2, 0);
    bus_read(16'h6055, 1, 1, d, o1, o2);
    chk("R3 outside read no drive", o2, 0);
    chk("R5 ad_o zero when not driving", d, 0);

    rw0 = n_rw; mw0 = n_mw;
    bus_write(16'h3FFF, 8'hFA, 1, p2, p3);
    chk("R8 base write no reg pulse", n_rw, rw0);
    chk("R8 base write no mem pulse", n_mw, mw0);
    chk("R8 base write keeps wr_addr", wr_addr, 13'h1FF3);
    bus_read(16'h5FFF, 0, 1, d, o1, o2);
    chk("R8 new base reads back", d, 8'h02);
    bus_read(16'h2055, 1, 1, d, o1, o2);
    chk("R3 old window deselected", o2, 0);
    bus_write(16'h4010, 8'h5A, 1, p2, p3);
    chk("R3 new window write", wr_addr, 13'h0010);
    chk("R7 new window wdata", wdata, 8'h5A);

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule